// File: doc/BRIEF.md
# Hamming Sector ECC Checker and Corrector

This block decides what a single-error-correcting Hamming check says about one 512-byte sector. It receives two 3-byte check codes. One is the code kept with the sector in storage. The other was recomputed from the sector data as it was read back. Each code is rearranged into a 32-bit word, and the two words are XORed to form a syndrome. The number of set bits in the syndrome selects one of five outcomes: clean, corrected single-bit data error, damaged check field, erased sector, or uncorrectable.

When a correctable data error is found, the block reports the byte and bit that are wrong. If the caller asked for repair, the block also fixes the error in the sector buffer. It reads the faulty byte through a synchronous memory port with one cycle of read latency, flips the bit, and writes the byte back. The done pulse is raised only after that write.

Each run starts with a one-cycle start strobe. Start strobes that arrive while a run is still in progress are dropped.

Top module: `hsec_check`

## Requirements
- R1: Each code is given as bits [7:0] = byte0, [15:8] = byte1, [23:16] = byte2. It is rearranged into a 32-bit word as follows: byte0 goes to [7:0], byte1 to [23:16], the upper nibble of byte2 to [27:24], the lower nibble of byte2 to [11:8], and all other bits are zero. The syndrome is the XOR of the two words. A zero syndrome reports status 0 (clean).
- R2: A syndrome with exactly 12 set bits reports status 1 (corrected). The bit index is syndrome [18:16] and the byte index is syndrome [27:19], giving a byte in the range 0 to 511.
- R3: A syndrome with exactly one set bit reports status 2 (check field damaged), and the sector buffer is never written.
- R4: If the stored word equals 0x0FFF0FFF (all three stored bytes are 0xFF) and the computed code is zero, the status is 3 (erased).
- R5: Every other nonzero syndrome reports status 4 (uncorrectable).
- R6: When the status is not 1, the byte index and the bit index are both zero.
- R7: Without repair, done is high for exactly one cycle, two clock edges after the edge that samples start. The status and indices are valid in that same cycle and stay held until the next run.
- R8: With repair requested and status 1, the block reads the addressed byte and then writes back that byte XOR (1 << bit index). Done goes high for one cycle, four edges after start, in the cycle after the write.
- R9: With repair requested and any status other than 1, there is no memory read or write, and the timing of R7 applies.
- R10: A start strobe that arrives while a run is busy is ignored. Each accepted start produces exactly one done pulse.
- R11: During reset and after it, done, the read and write enables, the status and the indices are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one check (one-cycle strobe) |
| fix_en | input | 1 | Repair the sector buffer if the error is correctable |
| stored_code | input | 24 | Check code read back from storage |
| calc_code | input | 24 | Check code recomputed from the data |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 clean, 1 corrected, 2 check field damaged, 3 erased, 4 uncorrectable |
| byte_idx | output | 9 | Byte position of the error |
| bit_idx | output | 3 | Bit position of the error |
| mem_rd_en | output | 1 | Sector buffer read request |
| mem_wr_en | output | 1 | Sector buffer write request |
| mem_addr | output | 9 | Sector buffer byte address |
| mem_wdata | output | 8 | Repaired byte |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd_en |

## Verification
The assertions assume two things about the environment. First, the sector buffer returns read data exactly one cycle after a read request. Second, the codes and fix_en are stable during the cycle in which start is sampled. The bench meets both conditions. Its memory model answers every read one cycle after the request. It drives codes, fix_en and start together on the falling edge and drops start again one cycle later.

The busy case is the only place where start is held over a second edge. There the second set of codes is deliberately different from the first, so that if the DUT accepted them the mismatch would show up in the result.

// File: rtl/hsec_pkg.sv
package hsec_pkg;
  localparam int CODE_W     = 24;
  localparam int WORD_W     = 32;
  localparam int BYTE_IDX_W = 9;
  localparam int BIT_IDX_W  = 3;
  localparam int DATA_W     = 8;
  localparam int CNT_W      = $clog2(WORD_W + 1);
  localparam int PAR_LSB    = 16;

  typedef enum logic [2:0] {
    ST_CLEAN  = 3'd0,
    ST_FIXED  = 3'd1,
    ST_ECCBAD = 3'd2,
    ST_ERASED = 3'd3,
    ST_UNCORR = 3'd4
  } hsec_status_e;

  // Spread a 3-byte code into the 32-bit syndrome layout.
  function automatic logic [WORD_W-1:0] hsec_repack(input logic [CODE_W-1:0] c);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[7:0]   = c[7:0];
    w[23:16] = c[15:8];
    w[27:24] = c[23:20];
    w[11:8]  = c[19:16];
    return w;
  endfunction
endpackage

// File: rtl/hsec_syndrome.sv
module hsec_syndrome
  import hsec_pkg::*;
(
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output logic [WORD_W-1:0] stored_word,
  output logic [WORD_W-1:0] calc_word,
  output logic [WORD_W-1:0] syndrome,
  output logic [CNT_W-1:0]  weight
);
  logic [CNT_W-1:0] partial [WORD_W+1];

  assign stored_word = hsec_repack(stored_code);
  assign calc_word   = hsec_repack(calc_code);
  assign syndrome    = stored_word ^ calc_word;

  // Ripple population count, one adder stage per syndrome bit.
  assign partial[0] = '0;
  for (genvar g = 0; g < WORD_W; g++) begin : g_pop
    assign partial[g+1] = partial[g] + CNT_W'(syndrome[g]);
  end
  assign weight = partial[WORD_W];
endmodule

// File: rtl/hsec_classify.sv
module hsec_classify
  import hsec_pkg::*;
#(
  parameter logic [WORD_W-1:0] ERASED_WORD = 32'h0FFF_0FFF,
  parameter int                FIX_WEIGHT  = 12
) (
  input  logic [WORD_W-1:0]     syndrome,
  input  logic [CNT_W-1:0]      weight,
  input  logic [WORD_W-1:0]     stored_word,
  input  logic [WORD_W-1:0]     calc_word,
  output hsec_status_e          status,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [BIT_IDX_W-1:0]  bit_idx
);
  localparam logic [CNT_W-1:0] FIX_CNT = CNT_W'(FIX_WEIGHT);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  always_comb begin
    status   = ST_CLEAN;
    byte_idx = '0;
    bit_idx  = '0;
    if (syndrome == '0) begin
      status = ST_CLEAN;
    end else if (weight == FIX_CNT) begin
      status   = ST_FIXED;
      bit_idx  = syndrome[PAR_LSB +: BIT_IDX_W];
      byte_idx = syndrome[PAR_LSB + BIT_IDX_W +: BYTE_IDX_W];
    end else if (weight == ONE_CNT) begin
      status = ST_ECCBAD;
    end else if ((stored_word == ERASED_WORD) && (calc_word == '0)) begin
      status = ST_ERASED;
    end else begin
      status = ST_UNCORR;
    end
  end
endmodule

// File: rtl/hsec_rmw.sv
module hsec_rmw
  import hsec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [BYTE_IDX_W-1:0] go_addr,
  input  logic [BIT_IDX_W-1:0]  go_bit,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  mem_rd_en,
  output logic                  mem_wr_en,
  output logic [BYTE_IDX_W-1:0] mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic                  last
);
  typedef enum logic [1:0] {RMW_IDLE, RMW_RD, RMW_WR} rmw_state_e;

  rmw_state_e              state_q, state_d;
  logic [BYTE_IDX_W-1:0]   addr_q;
  logic [BIT_IDX_W-1:0]    bit_q;
  logic                    cap_en;
  logic [DATA_W-1:0]       flip_mask;

  assign cap_en = go && (state_q == RMW_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      RMW_IDLE: if (go) state_d = RMW_RD;
      RMW_RD:   state_d = RMW_WR;
      RMW_WR:   state_d = RMW_IDLE;
      default:  state_d = RMW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RMW_IDLE;
      addr_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        addr_q <= go_addr;
        bit_q  <= go_bit;
      end
    end
  end

  assign flip_mask = DATA_W'(1) << bit_q;
  assign mem_rd_en = (state_q == RMW_RD);
  assign mem_wr_en = (state_q == RMW_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = mem_rdata ^ flip_mask;
  assign last      = (state_q == RMW_WR);

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en)) else $error("write without read"); // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $stable(mem_addr)) else $error("address moved"); // R8
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)) else $error("read and write together"); // R8
endmodule

// File: rtl/hsec_check.sv
module hsec_check
  import hsec_pkg::*;
#(
  parameter logic [WORD_W-1:0] ERASED_WORD     = 32'h0FFF_0FFF,
  parameter int                FIX_WEIGHT      = 12,
  parameter int                RST_SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  fix_en,
  input  logic [CODE_W-1:0]     stored_code,
  input  logic [CODE_W-1:0]     calc_code,
  output logic                  done,
  output logic [2:0]            status,
  output logic [BYTE_IDX_W-1:0] byte_idx,
  output logic [BIT_IDX_W-1:0]  bit_idx,
  output logic                  mem_rd_en,
  output logic                  mem_wr_en,
  output logic [BYTE_IDX_W-1:0] mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata
);
  typedef enum logic [1:0] {T_IDLE, T_EVAL, T_FIX} top_state_e;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [RST_SYNC_STAGES-1:0] rst_pipe;
  logic                       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[RST_SYNC_STAGES-1];

  top_state_e              state_q, state_d;
  logic [CODE_W-1:0]       stored_q, calc_q;
  logic                    fix_q;
  hsec_status_e            status_q;
  logic [BYTE_IDX_W-1:0]   byte_q;
  logic [BIT_IDX_W-1:0]    bit_q;
  logic                    done_q, done_d;
  logic                    accept, res_en, rmw_go, rmw_last;

  logic [WORD_W-1:0]       stored_word, calc_word, syndrome;
  logic [CNT_W-1:0]        weight;
  hsec_status_e            cls_status;
  logic [BYTE_IDX_W-1:0]   cls_byte;
  logic [BIT_IDX_W-1:0]    cls_bit;

  hsec_syndrome u_syn (
    .stored_code (stored_q),
    .calc_code   (calc_q),
    .stored_word (stored_word),
    .calc_word   (calc_word),
    .syndrome    (syndrome),
    .weight      (weight)
  );

  hsec_classify #(
    .ERASED_WORD (ERASED_WORD),
    .FIX_WEIGHT  (FIX_WEIGHT)
  ) u_cls (
    .syndrome    (syndrome),
    .weight      (weight),
    .stored_word (stored_word),
    .calc_word   (calc_word),
    .status      (cls_status),
    .byte_idx    (cls_byte),
    .bit_idx     (cls_bit)
  );

  assign accept = start && (state_q == T_IDLE);
  assign res_en = (state_q == T_EVAL);
  assign rmw_go = res_en && fix_q && (cls_status == ST_FIXED);

  hsec_rmw u_rmw (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .go        (rmw_go),
    .go_addr   (cls_byte),
    .go_bit    (cls_bit),
    .mem_rdata (mem_rdata),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .last      (rmw_last)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      T_IDLE: if (accept) state_d = T_EVAL;
      T_EVAL: begin
        if (rmw_go) begin
          state_d = T_FIX;
        end else begin
          state_d = T_IDLE;
          done_d  = 1'b1;
        end
      end
      T_FIX: begin
        if (rmw_last) begin
          state_d = T_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q  <= T_IDLE;
      stored_q <= '0;
      calc_q   <= '0;
      fix_q    <= 1'b0;
      status_q <= ST_CLEAN;
      byte_q   <= '0;
      bit_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept) begin
        stored_q <= stored_code;
        calc_q   <= calc_code;
        fix_q    <= fix_en;
      end
      if (res_en) begin
        status_q <= cls_status;
        byte_q   <= cls_byte;
        bit_q    <= cls_bit;
      end
    end
  end

  assign done     = done_q;
  assign status   = status_q;
  assign byte_idx = byte_q;
  assign bit_idx  = bit_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done) else $error("done longer than one cycle"); // R7
  AST_WRITE_ONLY_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_en |-> (status_q == ST_FIXED)) else $error("write for non-correctable"); // R3
  AST_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && (status_q != ST_FIXED)) |-> (byte_idx == '0 && bit_idx == '0))
    else $error("index not zero"); // R6
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> $past(state_q != T_IDLE)) else $error("done without run"); // R10
  AST_NO_MEM_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == T_IDLE) |-> !(mem_rd_en || mem_wr_en)) else $error("memory access idle"); // R9
endmodule

// File: tb/hsec_check_tb.sv
`timescale 1ns/1ps
module hsec_check_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, fix_en;
  logic [23:0] stored_code, calc_code;
  logic        done;
  logic [2:0]  status;
  logic [8:0]  byte_idx;
  logic [2:0]  bit_idx;
  logic        mem_rd_en, mem_wr_en;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  always #2 clk = ~clk;

  hsec_check u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fix_en(fix_en),
    .stored_code(stored_code), .calc_code(calc_code), .done(done),
    .status(status), .byte_idx(byte_idx), .bit_idx(bit_idx),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Sector buffer model: preloaded while reset is held, one-cycle read latency.
  logic [7:0] mem [512];
  int         wr_cnt = 0;
  int         rd_cnt = 0;
  int         pl_idx = 0;

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 5) ^ (a >> 3));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      if (pl_idx < 512) begin
        mem[pl_idx] <= init_val(pl_idx);
        pl_idx      <= pl_idx + 1;
      end
    end else begin
      if (mem_rd_en) begin
        mem_rdata <= mem[mem_addr];
        rd_cnt    <= rd_cnt + 1;
      end
      if (mem_wr_en) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt        <= wr_cnt + 1;
      end
    end
  end

  logic [7:0] shadow [512];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack_w(input logic [23:0] c);
    logic [31:0] w = 32'h0;
    w[7:0] = c[7:0]; w[23:16] = c[15:8]; w[27:24] = c[23:20]; w[11:8] = c[19:16];
    return w;
  endfunction

  function automatic logic [23:0] unpack_w(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  function automatic logic [31:0] fix_syn(input logic [8:0] b, input logic [2:0] k);
    logic [11:0] p = {b, k};
    return {4'h0, p, 4'h0, ~p};
  endfunction

  function automatic int exp_status(input logic [23:0] st, input logic [23:0] ca);
    logic [31:0] s = pack_w(st) ^ pack_w(ca);
    int n = $countones(s);
    if (s == 32'h0) return 0;
    if (n == 12) return 1;
    if (n == 1) return 2;
    if (pack_w(st) == 32'h0FFF0FFF && ca == 24'h0) return 3;
    return 4;
  endfunction

  task automatic run_case(input logic [23:0] st, input logic [23:0] ca, input bit fx);
    int es, eb, ek, lat, w0, r0, ew;
    logic [31:0] s;
    s  = pack_w(st) ^ pack_w(ca);
    es = exp_status(st, ca);
    eb = (es == 1) ? int'(s[27:19]) : 0;
    ek = (es == 1) ? int'(s[18:16]) : 0;
    ew = (fx && es == 1) ? 1 : 0;
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk);
    stored_code = st; calc_code = ca; fix_en = fx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(done, "R10 done seen", int'(done), 1);
    chk(lat == (ew ? 4 : 2), ew ? "R8 latency" : "R7 latency", lat, ew ? 4 : 2);
    chk(int'(status) == es, es == 0 ? "R1 status" : es == 1 ? "R2 status" :
        es == 2 ? "R3 status" : es == 3 ? "R4 status" : "R5 status", int'(status), es);
    chk(int'(byte_idx) == eb, es == 1 ? "R2 byte" : "R6 byte", int'(byte_idx), eb);
    chk(int'(bit_idx) == ek, es == 1 ? "R2 bit" : "R6 bit", int'(bit_idx), ek);
    chk(wr_cnt - w0 == ew, ew ? "R8 one write" : (es == 2 ? "R3 no write" : "R9 no write"),
        wr_cnt - w0, ew);
    chk(rd_cnt - r0 == ew, ew ? "R8 one read" : "R9 no read", rd_cnt - r0, ew);
    if (ew == 1) begin
      shadow[eb] = shadow[eb] ^ (8'h1 << ek);
      chk(mem[eb] == shadow[eb], "R8 byte repaired", int'(mem[eb]), int'(shadow[eb]));
    end
    @(negedge clk);
    chk(!done, "R7 single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] c;
    void'($urandom(32'd20240611));
    start = 0; fix_en = 0; stored_code = '0; calc_code = '0;
    rst_n = 1'b0;
    for (int i = 0; i < 512; i++) shadow[i] = init_val(i);
    repeat (530) @(negedge clk);
    chk(!done && !mem_rd_en && !mem_wr_en, "R11 reset outputs", int'(done), 0);
    chk(status == 3'd0 && byte_idx == 9'd0 && bit_idx == 3'd0, "R11 reset result",
        int'(status), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!done && status == 3'd0, "R11 after release", int'(status), 0);

    // Directed corners
    run_case(24'h123456, 24'h123456, 1'b0);                          // R1 clean
    run_case(24'hFFFFFF, 24'h000000, 1'b0);                          // R4 erased
    run_case(24'hFFFFFF, 24'h000001, 1'b0);                          // R5 near-erased
    c = 24'h5A3C91;
    run_case(c ^ unpack_w(fix_syn(9'd0, 3'd0)), c, 1'b0);            // R2 byte 0 bit 0
    run_case(c ^ unpack_w(fix_syn(9'd511, 3'd7)), c, 1'b1);          // R8 last byte
    run_case(c ^ unpack_w(fix_syn(9'd0, 3'd0)), c, 1'b1);            // R8 first byte
    run_case(c ^ 24'h000100, c, 1'b1);                               // R3 single bit, no write
    run_case(c ^ 24'h800000, c, 1'b0);                               // R3 top bit of byte2
    run_case(c ^ 24'h000003, c, 1'b1);                               // R5/R9 two bits
    run_case(24'h000000, 24'hFFFFFF, 1'b1);                          // R5 reversed erased

    // R10: start held across the busy cycle with different codes
    begin
      int dn = 0;
      @(negedge clk);
      stored_code = c ^ 24'h000100; calc_code = c; fix_en = 0; start = 1'b1;
      @(negedge clk);
      stored_code = 24'hFFFFFF; calc_code = 24'h0;
      if (done) dn++;
      @(negedge clk);
      start = 1'b0;
      if (done) dn++;
      chk(int'(status) == 2, "R10 busy start ignored", int'(status), 2);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (done) dn++;
      end
      chk(dn == 1, "R10 one done per accepted start", dn, 1);
    end

    // Random mix
    for (int it = 0; it < 60; it++) begin
      int kind = int'($urandom % 5);
      logic [23:0] ca = 24'($urandom);
      logic [23:0] st;
      bit fx = 1'($urandom);
      case (kind)
        0: st = ca;
        1: st = ca ^ unpack_w(fix_syn(9'($urandom), 3'($urandom)));
        2: st = ca ^ (24'h1 << ($urandom % 24));
        3: begin st = 24'hFFFFFF; ca = 24'h0; end
        default: st = ca ^ 24'($urandom);
      endcase
      run_case(st, ca, fx);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule